// File: doc/BRIEF.md
# Multi-Chip Memory Bank Composer

This block builds one wide memory out of several identical small memory chips. The chips sit in groups called banks. Each bank is as wide as the memory's access width, so every chip in a bank holds its own byte lane of each word. A decoder on the top address bits enables one bank for an access. The address bits just below it drive the address inputs of every chip in parallel. When the access width is wider than the addressable unit, the lowest address bits select a unit inside the word. A whole-word memory ignores them.

The port has no chip select. Read and write enables alone decide what happens. Both low is idle, write alone stores `din`, and read alone returns a word on `dout`. Both high is not allowed; the block treats it as idle. Writes happen on the rising clock edge. Reads are combinational from the enabled bank.

Every chip is a small behavioural array, and reset clears it. Chip depth, chip width, access width, unit width and chip count are parameters. A configuration whose access width is narrower than the unit, or whose widths or counts do not divide evenly, fails at elaboration.

With the default parameters there are 16 chips of 4 x 8 bits, 32-bit words and 8-bit units. The chips form 4 banks of 4 chips. The address is 6 bits wide:
- bits [5:4] pick the bank;
- bits [3:2] are the chip address;
- bits [1:0] are ignored.

Top module: `mem_bank_composer`

## Requirements
- R1: After reset every location reads as zero.
- R2: A write with `we`=1 and `re`=0 stores `din`, and a later read at the same address returns it.
- R3: When exactly one of `re`/`we` is high, `bank_sel` is one-hot, with bit k set, where k is the bank field (the top `log2(banks)` address bits, [5:4] by default).
- R4: When `re` and `we` are both low, or both high, `bank_sel` is all zero.
- R5: The lowest `log2(ACC_W/UNIT_W)` address bits ([1:0] by default) have no effect on which word is read or written.
- R6: With `re` and `we` both high, nothing is written and `dout` is zero.
- R7: `dout` is zero whenever the port is not doing a read (`re`=0 or `we`=1).
- R8: Different chip addresses inside a bank, and different banks at the same chip address, hold independent words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes on rising edge |
| rst_n | input | 1 | Active-low asynchronous reset, clears all chips |
| re | input | 1 | Read enable |
| we | input | 1 | Write enable |
| addr | input | ADDR_W (6) | Unit address: bank field, chip address, ignored low bits |
| din | input | ACC_W (32) | Write data, one slice per chip of the bank |
| dout | output | ACC_W (32) | Read data from the enabled bank, zero when not reading |
| bank_sel | output | BANKS (4) | One-hot bank enable lines |

## Verification
The bench writes different words to different banks and chip addresses and reads them back to catch aliasing. A decoder that took the wrong address bits would return one word at two addresses, or zero where data was stored. Reads with the low address bits changed must still hit the stored word. A design that kept those bits in the chip address would miss.

The forbidden case with both enables high gets a data write, and the bench then reads that word back. A design that honoured the write would show the new value there. The bench also checks that idle and write cycles drive `dout` to zero, and that a reset in the middle of a run clears stored data.

// File: rtl/mem_bank_composer.sv
module mem_bank_composer #(
  parameter int UNIT_W     = 8,
  parameter int ACC_W      = 32,
  parameter int CHIP_W     = 8,
  parameter int CHIP_DEPTH = 4,
  parameter int NUM_CHIPS  = 16,
  localparam int PER_BANK  = ACC_W / CHIP_W,
  localparam int BANKS     = NUM_CHIPS / PER_BANK,
  localparam int DROP_W    = $clog2(ACC_W / UNIT_W),
  localparam int CA_W      = $clog2(CHIP_DEPTH),
  localparam int BK_W      = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int BK_BITS   = (BANKS > 1) ? $clog2(BANKS) : 0,
  localparam int ADDR_W    = BK_BITS + CA_W + DROP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              re,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ACC_W-1:0]  din,
  output logic [ACC_W-1:0]  dout,
  output logic [BANKS-1:0]  bank_sel
);

  if (ACC_W < UNIT_W) begin : g_bad_ratio
    $error("access width narrower than addressable unit");
  end
  if (ACC_W % CHIP_W != 0 || NUM_CHIPS % PER_BANK != 0 || ACC_W % UNIT_W != 0) begin : g_bad_div
    $error("widths or chip count do not divide evenly");
  end

  logic           rd_op, wr_op;
  logic [BK_W-1:0] bank;
  logic [CA_W-1:0] caddr;

  assign rd_op = re & ~we;
  assign wr_op = we & ~re;
  assign caddr = addr[DROP_W +: CA_W];

  if (BANKS > 1) begin : g_bank_field
    assign bank = addr[ADDR_W-1 -: BK_BITS];
  end else begin : g_one_bank
    assign bank = '0;
  end

  always_comb begin
    bank_sel = '0;
    if (rd_op | wr_op) bank_sel[bank] = 1'b1;
  end

  logic [CHIP_W-1:0] chip_q [NUM_CHIPS];

  for (genvar c = 0; c < NUM_CHIPS; c++) begin : g_chip
    localparam int LANE = c % PER_BANK;
    localparam int BK   = c / PER_BANK;
    logic [CHIP_W-1:0] cells [CHIP_DEPTH];
    logic              cs;

    assign cs = bank_sel[BK];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int d = 0; d < CHIP_DEPTH; d++) cells[d] <= '0;
      end else if (cs && wr_op) begin
        cells[caddr] <= din[LANE*CHIP_W +: CHIP_W];
      end
    end

    assign chip_q[c] = cells[caddr];
  end

  always_comb begin
    dout = '0;
    if (rd_op) begin
      for (int k = 0; k < BANKS; k++)
        if (bank_sel[k])
          for (int l = 0; l < PER_BANK; l++)
            dout[l*CHIP_W +: CHIP_W] = chip_q[k*PER_BANK + l];
    end
  end

endmodule

// File: rtl/mem_bank_composer_chk.sv
module mem_bank_composer_chk #(
  parameter int ADDR_W = 6,
  parameter int ACC_W  = 32,
  parameter int BANKS  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              re,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [ACC_W-1:0]  dout,
  input logic [BANKS-1:0]  bank_sel
);
  localparam int BK_BITS = (BANKS > 1) ? $clog2(BANKS) : 0;

  function automatic logic [BANKS-1:0] want_sel(input logic [ADDR_W-1:0] a);
    want_sel = '0;
    if (BANKS > 1) want_sel[a >> (ADDR_W - BK_BITS)] = 1'b1;
    else want_sel[0] = 1'b1;
  endfunction

  // R3
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (re ^ we) |-> ($countones(bank_sel) == 1));

  // R3
  sel_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (re ^ we) |-> (bank_sel == want_sel(addr)));

  // R4
  sel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (re == we) |-> (bank_sel == '0));

  // R7
  dout_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!re || we) |-> (dout == '0));

  // R6
  both_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (re && we) |-> (dout == '0 && bank_sel == '0));
endmodule

bind mem_bank_composer mem_bank_composer_chk #(
  .ADDR_W(ADDR_W), .ACC_W(ACC_W), .BANKS(BANKS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .re(re), .we(we), .addr(addr),
  .dout(dout), .bank_sel(bank_sel)
);

// File: tb/mem_bank_composer_bench.sv
`timescale 1ns/1ps
module mem_bank_composer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        re = 1'b0, we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] din = '0;
  logic [31:0] dout;
  logic [3:0]  bank_sel;

  int n_cmp = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  mem_bank_composer u_mem_bank_composer (
    .clk(clk), .rst_n(rst_n), .re(re), .we(we), .addr(addr),
    .din(din), .dout(dout), .bank_sel(bank_sel)
  );

  typedef struct packed {
    logic        r;
    logic        w;
    logic [5:0]  a;
    logic [31:0] d;
    logic [31:0] xq;
    logic [3:0]  xs;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 6'h00, 32'hA1B2C3D4, 32'h0,        4'b0001}, // R2 R7 R3 write bank0 ca0
    '{1'b1, 1'b0, 6'h00, 32'h0,        32'hA1B2C3D4, 4'b0001}, // R2 readback
    '{1'b1, 1'b0, 6'h03, 32'h0,        32'hA1B2C3D4, 4'b0001}, // R5 low bits ignored
    '{1'b0, 1'b1, 6'h06, 32'h11223344, 32'h0,        4'b0001}, // R5 write ca1 with low bits 2
    '{1'b1, 1'b0, 6'h04, 32'h0,        32'h11223344, 4'b0001}, // R5 R8
    '{1'b1, 1'b0, 6'h00, 32'h0,        32'hA1B2C3D4, 4'b0001}, // R8 no alias in bank
    '{1'b0, 1'b1, 6'h31, 32'hDEADBEEF, 32'h0,        4'b1000}, // R3 bank3
    '{1'b1, 1'b0, 6'h30, 32'h0,        32'hDEADBEEF, 4'b1000}, // R3
    '{1'b1, 1'b0, 6'h10, 32'h0,        32'h0,        4'b0010}, // R8 R1 other bank untouched
    '{1'b1, 1'b1, 6'h00, 32'hFFFFFFFF, 32'h0,        4'b0000}, // R6 R4 both high
    '{1'b1, 1'b0, 6'h00, 32'h0,        32'hA1B2C3D4, 4'b0001}, // R6 no write happened
    '{1'b0, 1'b0, 6'h20, 32'h12345678, 32'h0,        4'b0000}, // R4 R7 idle
    '{1'b0, 1'b1, 6'h2C, 32'h0F0F0F0F, 32'h0,        4'b0100}, // R3 bank2 ca3
    '{1'b1, 1'b0, 6'h2F, 32'h0,        32'h0F0F0F0F, 4'b0100}  // R2 R5
  };

  task automatic check(input string req, input logic [31:0] got_q, input logic [31:0] exp_q,
                       input logic [3:0] got_s, input logic [3:0] exp_s);
    n_cmp++;
    if (got_q !== exp_q || got_s !== exp_s) begin
      n_bad++;
      $display("FAIL %s: dout=%h bank_sel=%b expected dout=%h bank_sel=%b",
               req, got_q, got_s, exp_q, exp_s);
    end
  endtask

  task automatic drive(input logic r, input logic w, input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    re = r; we = w; addr = a; din = d;
    #1;
  endtask

  initial begin : watchdog
    #200000;
    n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset outputs", dout, 32'h0, bank_sel, 4'b0000);
    rst_n = 1'b1;

    // R1: every location reads zero after reset
    for (int b = 0; b < 4; b++)
      for (int c = 0; c < 4; c++) begin
        logic [3:0] s;
        s = 4'b0001 << b;
        drive(1'b1, 1'b0, {b[1:0], c[1:0], 2'b00}, 32'h0);
        check("R1 cleared location", dout, 32'h0, bank_sel, s);
      end

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].r, VEC[i].w, VEC[i].a, VEC[i].d);
      check($sformatf("vector %0d (R2-R8 table)", i), dout, VEC[i].xq, bank_sel, VEC[i].xs);
    end

    // R8: same chip address, every bank distinct
    for (int b = 0; b < 4; b++)
      drive(1'b0, 1'b1, {b[1:0], 4'b0101}, 32'hC0DE0000 + b);
    for (int b = 0; b < 4; b++) begin
      logic [3:0] s;
      s = 4'b0001 << b;
      drive(1'b1, 1'b0, {b[1:0], 4'b0100}, 32'h0);
      check("R8 bank independence", dout, 32'hC0DE0000 + b, bank_sel, s);
    end

    // R7: write cycle keeps dout at zero even over stored data
    drive(1'b0, 1'b1, 6'h00, 32'h55AA55AA);
    check("R7 dout zero during write", dout, 32'h0, bank_sel, 4'b0001);
    drive(1'b1, 1'b0, 6'h01, 32'h0);
    check("R2 overwrite", dout, 32'h55AA55AA, bank_sel, 4'b0001);

    // R1: reset mid-run clears stored data
    drive(1'b0, 1'b0, 6'h00, 32'h0);
    rst_n = 1'b0;
    #3;
    rst_n = 1'b1;
    drive(1'b1, 1'b0, 6'h00, 32'h0);
    check("R1 cleared after reset", dout, 32'h0, bank_sel, 4'b0001);
    drive(1'b1, 1'b0, 6'h30, 32'h0);
    check("R1 cleared after reset", dout, 32'h0, bank_sel, 4'b1000);

    drive(1'b0, 1'b0, 6'h00, 32'h0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule